// File: doc/BRIEF.md
# Victim Block Buffer

This block is a small fully associative store that sits beside a direct-mapped data cache and keeps the blocks that the cache has just thrown out. Each time the cache displaces a block, it hands the block over with its block address and its dirty bit. The buffer is searched only when the main cache misses. If the search hits, the buffer returns the block. The block that the cache is evicting at that moment then takes over the freed slot, so the two blocks swap places. If the search misses, the request goes on to the next memory level. A conflict miss can therefore be served without any memory traffic, and the cache keeps its simple direct-mapped hit path.

Each slot holds the full block address as its tag, along with a valid bit, a dirty bit and the block data. New blocks fill free slots first. When every slot is occupied, the slot that was filled longest ago is overwritten. If that displaced block is dirty, it leaves through the write-back output. A swap counts as a fresh insertion for this ordering. A lookup that hits with no accompanying eviction hands the block back to the cache and frees its slot.

Top module: `victim_buffer`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty. `resp_valid` and `wb_valid` are low, and a lookup of any address reports `resp_hit` = 0.
- R2: `resp_valid` is high in exactly the cycle after a cycle with `lookup_valid` high, and low otherwise.
- R3: A block inserted through the eviction port is found by a later lookup of its address. The response then returns the block's data and dirty bit.
- R4: A lookup of an address held in no valid slot reports `resp_hit` = 0.
- R5: A lookup that hits while `evict_valid` is high returns the stored block and puts the evicted block into that same slot. The old address then misses, the new one hits, and no write-back is produced.
- R6: A lookup that hits while `evict_valid` is low returns the block and frees its slot, so a later lookup of that address misses.
- R7: An insertion while any slot is free uses a free slot and produces no write-back.
- R8: An insertion while all ENTRIES slots are valid overwrites the slot filled least recently. That slot's address misses afterwards, and the other slots are kept.
- R9: When the overwritten slot is dirty, `wb_valid` is high one cycle later with that block's address and data. When it is clean, `wb_valid` stays low.
- R10: A lookup and an eviction in the same cycle with the same address report a hit. The response returns the evicted block's data and dirty bit, and the block is stored.
- R11: A block that enters through a swap counts as the most recently filled slot in the replacement order.
- R12: A slot freed by a hit is reused by the next insertion without displacing any other block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evict_valid | input | 1 | Main cache is discarding a block this cycle |
| evict_addr | input | ADDR_W | Block address of the discarded block |
| evict_data | input | DATA_W | Contents of the discarded block |
| evict_dirty | input | 1 | Discarded block is modified |
| lookup_valid | input | 1 | Main cache missed; search the buffer |
| lookup_addr | input | ADDR_W | Block address being searched |
| resp_valid | output | 1 | Response to last cycle's lookup |
| resp_hit | output | 1 | The searched block was present |
| resp_data | output | DATA_W | Returned block (zero on a miss) |
| resp_dirty | output | 1 | Returned block is modified |
| wb_valid | output | 1 | A dirty block was displaced and must be written back |
| wb_addr | output | ADDR_W | Address of the displaced dirty block |
| wb_data | output | DATA_W | Contents of the displaced dirty block |

## Verification
Every result of this block comes one clock after the stimulus that causes it. Lookup responses, write-backs of displaced dirty blocks, and the visibility of a new insertion to later searches all follow this rule. The only exception is the same-address case, where the response is forwarded in that same next cycle. The bench drives each stimulus row on a falling edge and compares the outputs on the following falling edge. By then exactly one rising edge has updated the output registers, and the next row has not yet been sampled. The bench tracks the replacement order itself, so each row's expected write-back address comes from the order in which slots were filled, not from slot indices.

// File: rtl/vcb_pkg.sv
// Package vcb_pkg
// Shared types for the victim block buffer.
// Assumes: at most one slot action is taken per cycle.
package vcb_pkg;

    // Action applied to the slot array in one cycle
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_INSERT = 2'd1,
        SLOT_SWAP   = 2'd2,
        SLOT_DROP   = 2'd3
    } slot_op_e;

endpackage

// File: rtl/vcb_tag_match.sv
// Module vcb_tag_match
// Compares one search address against every slot tag in parallel.
// It reports a per-slot hit vector, an any-hit flag and the encoded
// index of the hitting slot.
// Assumes: the environment never stores the same address in two slots.
module vcb_tag_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 28,
    parameter int IDX_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           search_en,
    input  logic [ADDR_W-1:0]              search_addr,
    input  logic [ENTRIES-1:0]             slot_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] slot_tag,
    output logic [ENTRIES-1:0]             match_vec,
    output logic                           any_match,
    output logic [IDX_W-1:0]               match_idx
);

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = search_en && slot_valid[g] && (slot_tag[g] == search_addr);
    end

    assign any_match = |match_vec;

    // Encode the hitting slot into an index
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    // R3
    match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/vcb_age_tracker.sv
// Module vcb_age_tracker
// Keeps a fill-order rank for each slot. Rank 0 is the newest fill and
// ENTRIES-1 the oldest. It selects the slot for the next insertion:
// the lowest free slot if one exists, otherwise the oldest valid slot.
// Assumes: touch and drop are never requested in the same cycle, and
// valid_i is the slot valid vector before this cycle's update.
module vcb_age_tracker #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               drop_en,
    input  logic [IDX_W-1:0]   drop_idx,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic               full
);

    localparam logic [IDX_W-1:0] RANK_OLD = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] rank;
    logic [ENTRIES-1:0]            oldest_vec;
    logic [IDX_W-1:0]              oldest_idx;

    // Rank bookkeeping: touched slot becomes newest, dropped slot closes its gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank <= '0;
        end else if (touch_en) begin
            for (int o = 0; o < ENTRIES; o++) begin
                if (IDX_W'(o) == touch_idx) begin
                    rank[o] <= '0;
                end else if (valid_i[o] &&
                             (!valid_i[touch_idx] || rank[o] < rank[touch_idx])) begin
                    rank[o] <= rank[o] + 1'b1;
                end
            end
        end else if (drop_en) begin
            for (int o = 0; o < ENTRIES; o++) begin
                if (valid_i[o] && rank[o] > rank[drop_idx]) begin
                    rank[o] <= rank[o] - 1'b1;
                end
            end
        end
    end

    // Flag the slot whose rank marks it as the oldest fill
    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = valid_i[g] && (rank[g] == RANK_OLD);
    end

    assign full = &valid_i;

    // Encode the oldest slot into an index
    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest_vec[i]) oldest_idx = IDX_W'(i);
        end
    end

    // Choose the lowest free slot, or the oldest slot when none is free
    always_comb begin
        alloc_idx = oldest_idx;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) alloc_idx = IDX_W'(i);
        end
    end

    // R8
    oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> ($countones(oldest_vec) == 1));

    // R12
    no_double_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(touch_en && drop_en));

endmodule

// File: rtl/victim_buffer.sv
// Module victim_buffer
// Fully associative store for blocks discarded by a direct-mapped cache.
// It is searched on main-cache misses. A hit hands the block back,
// and a simultaneous eviction takes the freed slot (swap). Other
// evictions fill a free slot or overwrite the oldest fill, and a dirty
// block that is overwritten is sent to the write-back port.
// Assumes: an address is never stored twice, and lookups come only on
// main-cache misses. All outputs are registered, with one cycle latency.
module victim_buffer
    import vcb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 28,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [DATA_W-1:0] evict_data,
    input  logic              evict_dirty,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_dirty,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0]             ent_dirty;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
    logic [ENTRIES-1:0][DATA_W-1:0] ent_data;

    logic [ENTRIES-1:0] hit_vec;
    logic               cam_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   alloc_idx;
    logic               full;

    logic               same_addr;
    logic               buf_hit;
    slot_op_e           op;
    logic [IDX_W-1:0]   tgt_idx;
    logic               spill;
    logic               touch_en;
    logic               drop_en;

    vcb_tag_match #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) i_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .search_en   (lookup_valid),
        .search_addr (lookup_addr),
        .slot_valid  (ent_valid),
        .slot_tag    (ent_tag),
        .match_vec   (hit_vec),
        .any_match   (cam_hit),
        .match_idx   (hit_idx)
    );

    vcb_age_tracker #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) i_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (ent_valid),
        .touch_en  (touch_en),
        .touch_idx (tgt_idx),
        .drop_en   (drop_en),
        .drop_idx  (hit_idx),
        .alloc_idx (alloc_idx),
        .full      (full)
    );

    // Same-cycle lookup of the block being inserted takes the forward path
    assign same_addr = lookup_valid && evict_valid && (evict_addr == lookup_addr);
    assign buf_hit   = cam_hit && !same_addr;

    // Decide this cycle's slot action and the slot it writes
    always_comb begin
        if (buf_hit && evict_valid) begin
            op      = SLOT_SWAP;
            tgt_idx = hit_idx;
        end else if (buf_hit) begin
            op      = SLOT_DROP;
            tgt_idx = hit_idx;
        end else if (evict_valid) begin
            op      = SLOT_INSERT;
            tgt_idx = alloc_idx;
        end else begin
            op      = SLOT_IDLE;
            tgt_idx = alloc_idx;
        end
    end

    assign touch_en = (op == SLOT_INSERT) || (op == SLOT_SWAP);
    assign drop_en  = (op == SLOT_DROP);
    assign spill    = (op == SLOT_INSERT) && full && ent_dirty[alloc_idx];

    // Slot array update: fill or swap writes the target, drop clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            case (op)
                SLOT_INSERT, SLOT_SWAP: begin
                    ent_valid[tgt_idx] <= 1'b1;
                    ent_dirty[tgt_idx] <= evict_dirty;
                    ent_tag[tgt_idx]   <= evict_addr;
                    ent_data[tgt_idx]  <= evict_data;
                end
                SLOT_DROP: ent_valid[hit_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Lookup response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            resp_dirty <= 1'b0;
        end else begin
            resp_valid <= lookup_valid;
            resp_hit   <= same_addr || buf_hit;
            if (same_addr) begin
                resp_data  <= evict_data;
                resp_dirty <= evict_dirty;
            end else if (buf_hit) begin
                resp_data  <= ent_data[hit_idx];
                resp_dirty <= ent_dirty[hit_idx];
            end else begin
                resp_data  <= '0;
                resp_dirty <= 1'b0;
            end
        end
    end

    // Write-back register for a displaced dirty block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= spill;
            if (spill) begin
                wb_addr <= ent_tag[alloc_idx];
                wb_data <= ent_data[alloc_idx];
            end
        end
    end

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> resp_valid);

    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !resp_valid);

    // R9
    wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(evict_valid) && $past(&ent_valid)));

    // R5
    swap_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && cam_hit) |=> !wb_valid);

    // R4
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_hit |-> (resp_data == '0));

endmodule

// File: tb/test_victim_buffer.sv
// Bench test_victim_buffer
// Walks a table of stimulus rows. Each row is driven on a falling edge
// and checked on the next falling edge. Directed reset tests follow.
module test_victim_buffer;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 28;
    localparam int DATA_W = 64;
    localparam int NV     = 24;

    typedef struct packed {
        logic              ev;
        logic [ADDR_W-1:0] ea;
        logic              ed;
        logic              lv;
        logic [ADDR_W-1:0] la;
        logic              xhit;
        logic              xdirty;
        logic              xwb;
        logic [ADDR_W-1:0] xwba;
        logic [7:0]        req;
    } vec_t;

    // ev, ea, ed, lv, la, xhit, xdirty, xwb, xwba, req
    localparam vec_t VEC [NV] = '{
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h100, 1'b0, 1'b0, 1'b0, 28'h000, 8'd4},  // R4 empty
        '{1'b1, 28'h100, 1'b1, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd7},  // R7 A
        '{1'b1, 28'h200, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd7},  // R7 B
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h100, 1'b1, 1'b1, 1'b0, 28'h000, 8'd3},  // R3 hit A
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h100, 1'b0, 1'b0, 1'b0, 28'h000, 8'd6},  // R6 A freed
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h999, 1'b0, 1'b0, 1'b0, 28'h000, 8'd4},  // R4 absent
        '{1'b1, 28'h300, 1'b1, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd12}, // R12 C
        '{1'b1, 28'h400, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd7},  // R7 D
        '{1'b1, 28'h500, 1'b1, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd12}, // R12 E fills
        '{1'b1, 28'h600, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd9},  // R9 B clean out
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h200, 1'b0, 1'b0, 1'b0, 28'h000, 8'd8},  // R8 B gone
        '{1'b1, 28'h700, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b1, 28'h300, 8'd9},  // R9 C dirty out
        '{1'b1, 28'h800, 1'b1, 1'b1, 28'h400, 1'b1, 1'b0, 1'b0, 28'h000, 8'd5},  // R5 swap D/H
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h800, 1'b1, 1'b1, 1'b0, 28'h000, 8'd5},  // R5 H present
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h400, 1'b0, 1'b0, 1'b0, 28'h000, 8'd5},  // R5 D gone
        '{1'b1, 28'h900, 1'b1, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd12}, // R12 I
        '{1'b1, 28'hA00, 1'b1, 1'b1, 28'h600, 1'b1, 1'b0, 1'b0, 28'h000, 8'd11}, // R11 swap F/J
        '{1'b1, 28'hB00, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b1, 28'h500, 8'd11}, // R11 E out
        '{1'b1, 28'hC00, 1'b1, 1'b0, 28'h000, 1'b0, 1'b0, 1'b0, 28'h000, 8'd11}, // R11 G out
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'hA00, 1'b1, 1'b1, 1'b0, 28'h000, 8'd11}, // R11 J kept
        '{1'b1, 28'hD00, 1'b0, 1'b1, 28'hD00, 1'b1, 1'b0, 1'b0, 28'h000, 8'd10}, // R10 forward
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'h700, 1'b0, 1'b0, 1'b0, 28'h000, 8'd8},  // R8 G gone
        '{1'b1, 28'hE00, 1'b0, 1'b0, 28'h000, 1'b0, 1'b0, 1'b1, 28'h900, 8'd8},  // R8 I out
        '{1'b0, 28'h000, 1'b0, 1'b1, 28'hD00, 1'b1, 1'b0, 1'b0, 28'h000, 8'd10}  // R10 N stored
    };

    logic              clk;
    logic              rst_n;
    logic              evict_valid;
    logic [ADDR_W-1:0] evict_addr;
    logic [DATA_W-1:0] evict_data;
    logic              evict_dirty;
    logic              lookup_valid;
    logic [ADDR_W-1:0] lookup_addr;
    logic              resp_valid;
    logic              resp_hit;
    logic [DATA_W-1:0] resp_data;
    logic              resp_dirty;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    int checks = 0;
    int errors = 0;

    victim_buffer #(
        .ENTRIES (4),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) i_victim_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .evict_valid  (evict_valid),
        .evict_addr   (evict_addr),
        .evict_data   (evict_data),
        .evict_dirty  (evict_dirty),
        .lookup_valid (lookup_valid),
        .lookup_addr  (lookup_addr),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .resp_data    (resp_data),
        .resp_dirty   (resp_dirty),
        .wb_valid     (wb_valid),
        .wb_addr      (wb_addr),
        .wb_data      (wb_data)
    );

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    // Block contents derived from its address
    function automatic logic [DATA_W-1:0] mk(input logic [ADDR_W-1:0] a);
        return {4'h5, a, 4'hC, ~a};
    endfunction

    task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evict_valid  = 1'b0;
        evict_addr   = '0;
        evict_data   = '0;
        evict_dirty  = 1'b0;
        lookup_valid = 1'b0;
        lookup_addr  = '0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(64'(resp_valid), 64'(0), "R1", "resp_valid in reset");
        chk(64'(wb_valid), 64'(0), "R1", "wb_valid in reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            evict_valid  = VEC[i].ev;
            evict_addr   = VEC[i].ea;
            evict_data   = mk(VEC[i].ea);
            evict_dirty  = VEC[i].ed;
            lookup_valid = VEC[i].lv;
            lookup_addr  = VEC[i].la;
            @(negedge clk);
            // R2 response presence
            chk(64'(resp_valid), 64'(VEC[i].lv), "R2", $sformatf("row %0d resp_valid", i));
            if (VEC[i].lv) begin
                chk(64'(resp_hit), 64'(VEC[i].xhit), rq, $sformatf("row %0d resp_hit", i));
                if (VEC[i].xhit) begin
                    chk(resp_data, mk(VEC[i].la), rq, $sformatf("row %0d resp_data", i));
                    chk(64'(resp_dirty), 64'(VEC[i].xdirty), rq, $sformatf("row %0d resp_dirty", i));
                end
            end
            chk(64'(wb_valid), 64'(VEC[i].xwb), rq, $sformatf("row %0d wb_valid", i));
            if (VEC[i].xwb) begin
                chk(64'(wb_addr), 64'(VEC[i].xwba), rq, $sformatf("row %0d wb_addr", i));
                chk(wb_data, mk(VEC[i].xwba), rq, $sformatf("row %0d wb_data", i));
            end
        end

        // R1 reset while slots are occupied clears them
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(64'(resp_valid), 64'(0), "R1", "resp_valid after mid-run reset");
        chk(64'(wb_valid), 64'(0), "R1", "wb_valid after mid-run reset");
        rst_n = 1'b1;
        lookup_valid = 1'b1;
        lookup_addr  = 28'hC00;
        @(negedge clk);
        chk(64'(resp_valid), 64'(1), "R1", "resp_valid after reset lookup");
        chk(64'(resp_hit), 64'(0), "R1", "stored block lost by reset");
        idle_inputs();
        @(negedge clk);
        // R2 no response without a lookup
        chk(64'(resp_valid), 64'(0), "R2", "resp_valid idle");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule